// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block produces the control-memory address for a microprogrammed control unit. It holds the current control address and a single saved return address. Every enabled cycle it chooses the next control address. The choice depends on three fields of the current microinstruction: a 2-bit condition selector, a 2-bit branch kind and a 7-bit target address. It also depends on three datapath status bits and the four opcode bits taken from the data register.

The control memory and the datapath sit outside this block. The microinstruction fields arrive on plain input pins. The chosen address leaves on `car_q`, which drives the control-memory read port. The combinational `next_car` output shows the address that the next enabled edge will load. All pins are plain control and status signals and have no handshake. Holding `step_en` low freezes both internal registers, and this is the only way to stall the block.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous active-high `rst` sets `car_q` to 64 and `sbr_q` to 0. Reset takes priority over `step_en` and over every branch kind.
- R2: On a rising edge with `step_en` low and `rst` low, `car_q` and `sbr_q` keep their values, whatever the other inputs are.
- R3: `cond_hit` depends on `cond_sel` as follows: 0 gives constant 1, 1 gives `dr_ind`, 2 gives `ac_sign`, and 3 gives `ac_zero`.
- R4: `br_kind` 0 is a jump. It loads `br_addr` when `cond_hit` is 1. Otherwise it loads `car_q`+1 modulo 128, so 127 wraps to 0.
- R5: `br_kind` 1 is a call. With `cond_hit` 1 it loads `br_addr` into `car_q` and writes `car_q`+1 modulo 128 into `sbr_q`, both on the same edge. With `cond_hit` 0 it loads `car_q`+1.
- R6: `br_kind` 2 is a return. It loads the value of `sbr_q` into `car_q`, whatever `cond_hit` is.
- R7: `br_kind` 3 is an opcode map. It loads `{1'b0, dr_opcode, 2'b00}` into `car_q`, which is opcode×4, whatever `cond_hit` is.
- R8: `next_car` always equals the value that `car_q` takes at the next edge with `step_en` high and `rst` low.
- R9: `sbr_q` changes only on an enabled edge that carries a call with `cond_hit` 1. A later call overwrites the single saved address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Cycle enable for both registers |
| cond_sel | input | 2 | Condition selector field of the microinstruction |
| br_kind | input | 2 | Branch kind field: 0 jump, 1 call, 2 return, 3 map |
| br_addr | input | 7 | Target address field of the microinstruction |
| dr_ind | input | 1 | Indirect bit from the data register (bit 15) |
| ac_sign | input | 1 | Accumulator sign bit (bit 15) |
| ac_zero | input | 1 | Accumulator equals zero |
| dr_opcode | input | 4 | Opcode bits of the data register (bits 14..11) |
| cond_hit | output | 1 | Selected condition value |
| next_car | output | 7 | Address loaded at the next enabled edge |
| car_q | output | 7 | Current control address |
| sbr_q | output | 7 | Saved return address |

## Verification
A taken call does two things on the same edge: it redirects the control address and it writes the incremented old address into the return register. The bench provokes this with calls from address 127, where the saved value must wrap to 0 while the address becomes the call target. It also runs two calls back to back and then a return, which must land on the second saved address. Reset is also raised while an enabled jump is presented. The registers must go to 64 and 0, and the jump must leave no trace.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    BK_JUMP = 2'd0,
    BK_CALL = 2'd1,
    BK_RET  = 2'd2,
    BK_MAP  = 2'd3
  } br_kind_e;

  typedef enum logic [1:0] {
    CS_ALWAYS = 2'd0,
    CS_IND    = 2'd1,
    CS_SIGN   = 2'd2,
    CS_ZERO   = 2'd3
  } cond_sel_e;

endpackage

// File: rtl/useq_cond_mux.sv
module useq_cond_mux
  import useq_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       ind_bit,
  input  logic       sign_bit,
  input  logic       zero_bit,
  output logic       hit
);

  localparam int NSRC = 4;

  logic [NSRC-1:0] cand;

  assign cand = {zero_bit, sign_bit, ind_bit, 1'b1};

  always_comb begin
    case (cond_sel_e'(sel))
      CS_ALWAYS: hit = cand[0];
      CS_IND:    hit = cand[1];
      CS_SIGN:   hit = cand[2];
      CS_ZERO:   hit = cand[3];
      default:   hit = 1'b0;
    endcase
  end

  always_comb begin
    if (sel == CS_ALWAYS) begin
      AST_ALWAYS_TAKEN: assert (hit); // R3
    end
  end

endmodule

// File: rtl/useq_target_gen.sv
module useq_target_gen
  import useq_pkg::*;
#(
  parameter int AW        = 7,
  parameter int OPW       = 4,
  parameter int MAP_SHIFT = 2
) (
  input  logic [AW-1:0]  car,
  input  logic [AW-1:0]  sbr,
  input  logic [AW-1:0]  tgt,
  input  logic [OPW-1:0] opcode,
  input  logic [1:0]     kind,
  input  logic           hit,
  output logic [AW-1:0]  next_addr,
  output logic           link_we,
  output logic [AW-1:0]  link_val
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] car_inc;
  logic [AW-1:0] map_addr;

  assign car_inc = car + ONE;

  for (genvar g = 0; g < AW; g++) begin : g_map
    if (g >= MAP_SHIFT && g < MAP_SHIFT + OPW) begin : g_op
      assign map_addr[g] = opcode[g-MAP_SHIFT];
    end else begin : g_zero
      assign map_addr[g] = 1'b0;
    end
  end

  always_comb begin
    next_addr = car_inc;
    link_we   = 1'b0;
    case (br_kind_e'(kind))
      BK_JUMP: if (hit) next_addr = tgt;
      BK_CALL: if (hit) begin
        next_addr = tgt;
        link_we   = 1'b1;
      end
      BK_RET:  next_addr = sbr;
      BK_MAP:  next_addr = map_addr;
      default: next_addr = car_inc;
    endcase
  end

  assign link_val = car_inc;

  always_comb begin
    if (kind == BK_MAP) begin
      AST_MAP_ALIGNED: assert (next_addr[MAP_SHIFT-1:0] == '0); // R7
    end
  end

endmodule

// File: rtl/useq_link_reg.sv
module useq_link_reg #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)            q <= '0;
    else if (en && we)  q <= d;
  end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int AW         = 7,
  parameter int OPW        = 4,
  parameter int MAP_SHIFT  = 2,
  parameter int RESET_ADDR = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step_en,
  input  logic [1:0]     cond_sel,
  input  logic [1:0]     br_kind,
  input  logic [AW-1:0]  br_addr,
  input  logic           dr_ind,
  input  logic           ac_sign,
  input  logic           ac_zero,
  input  logic [OPW-1:0] dr_opcode,
  output logic           cond_hit,
  output logic [AW-1:0]  next_car,
  output logic [AW-1:0]  car_q,
  output logic [AW-1:0]  sbr_q
);

  localparam logic [AW-1:0] BOOT = AW'(RESET_ADDR);
  localparam logic [AW-1:0] ONE  = AW'(1);

  logic          link_we;
  logic [AW-1:0] link_val;

  useq_cond_mux u_cond (
    .sel      (cond_sel),
    .ind_bit  (dr_ind),
    .sign_bit (ac_sign),
    .zero_bit (ac_zero),
    .hit      (cond_hit)
  );

  useq_target_gen #(
    .AW        (AW),
    .OPW       (OPW),
    .MAP_SHIFT (MAP_SHIFT)
  ) u_tgt (
    .car       (car_q),
    .sbr       (sbr_q),
    .tgt       (br_addr),
    .opcode    (dr_opcode),
    .kind      (br_kind),
    .hit       (cond_hit),
    .next_addr (next_car),
    .link_we   (link_we),
    .link_val  (link_val)
  );

  useq_link_reg #(.AW(AW)) u_link (
    .clk (clk),
    .rst (rst),
    .en  (step_en),
    .we  (link_we),
    .d   (link_val),
    .q   (sbr_q)
  );

  always_ff @(posedge clk) begin
    if (rst)          car_q <= BOOT;
    else if (step_en) car_q <= next_car;
  end

  // Marks that the previous edge was outside reset.
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(step_en)) |-> ($stable(car_q) && $stable(sbr_q))); // R2

  AST_STEP_FOLLOWS_NEXT: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(step_en)) |-> (car_q == $past(next_car))); // R8

  AST_CALL_SAVES_LINK: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(step_en && br_kind == BK_CALL && cond_hit))
      |-> (sbr_q == $past(car_q + ONE))); // R5

  AST_LINK_ONLY_ON_CALL: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(step_en && br_kind == BK_CALL && cond_hit))
      |-> $stable(sbr_q)); // R9

  AST_RET_USES_LINK: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(step_en && br_kind == BK_RET))
      |-> (car_q == $past(sbr_q))); // R6

  AST_RESET_BOOT: assert property (@(posedge clk)
    $past(rst) |-> (car_q == BOOT && sbr_q == '0)); // R1

endmodule

// File: tb/sim_useq_sequencer.sv
`timescale 1ns/1ps
module sim_useq_sequencer;

  logic       clk = 1'b0;
  logic       rst;
  logic       step_en;
  logic [1:0] cond_sel;
  logic [1:0] br_kind;
  logic [6:0] br_addr;
  logic       dr_ind, ac_sign, ac_zero;
  logic [3:0] dr_opcode;
  logic       cond_hit;
  logic [6:0] next_car, car_q, sbr_q;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  useq_sequencer u0 (
    .clk(clk), .rst(rst), .step_en(step_en), .cond_sel(cond_sel),
    .br_kind(br_kind), .br_addr(br_addr), .dr_ind(dr_ind),
    .ac_sign(ac_sign), .ac_zero(ac_zero), .dr_opcode(dr_opcode),
    .cond_hit(cond_hit), .next_car(next_car), .car_q(car_q), .sbr_q(sbr_q)
  );

  // en | cd | br | ad | ind sign zero | op | exp cond | exp next | exp car | exp sbr
  localparam int NV = 23;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1,2'd0,2'd0,7'd10, 3'b000,4'd0, 1'b1,7'd10, 7'd10, 7'd0},
    {1'b1,2'd1,2'd0,7'd50, 3'b000,4'd0, 1'b0,7'd11, 7'd11, 7'd0},
    {1'b1,2'd1,2'd0,7'd50, 3'b100,4'd0, 1'b1,7'd50, 7'd50, 7'd0},
    {1'b1,2'd2,2'd1,7'd20, 3'b000,4'd0, 1'b0,7'd51, 7'd51, 7'd0},
    {1'b1,2'd2,2'd1,7'd20, 3'b010,4'd0, 1'b1,7'd20, 7'd20, 7'd52},
    {1'b0,2'd0,2'd0,7'd99, 3'b000,4'd0, 1'b1,7'd99, 7'd20, 7'd52},
    {1'b1,2'd3,2'd0,7'd5,  3'b000,4'd0, 1'b0,7'd21, 7'd21, 7'd52},
    {1'b1,2'd3,2'd0,7'd5,  3'b001,4'd0, 1'b1,7'd5,  7'd5,  7'd52},
    {1'b1,2'd0,2'd2,7'd0,  3'b000,4'd0, 1'b1,7'd52, 7'd52, 7'd52},
    {1'b1,2'd1,2'd3,7'd0,  3'b000,4'd11,1'b0,7'd44, 7'd44, 7'd52},
    {1'b1,2'd3,2'd2,7'd0,  3'b000,4'd0, 1'b0,7'd52, 7'd52, 7'd52},
    {1'b1,2'd0,2'd3,7'd0,  3'b000,4'd15,1'b1,7'd60, 7'd60, 7'd52},
    {1'b1,2'd0,2'd3,7'd0,  3'b000,4'd0, 1'b1,7'd0,  7'd0,  7'd52},
    {1'b1,2'd2,2'd2,7'd0,  3'b000,4'd0, 1'b0,7'd52, 7'd52, 7'd52},
    {1'b1,2'd0,2'd0,7'd127,3'b000,4'd0, 1'b1,7'd127,7'd127,7'd52},
    {1'b1,2'd1,2'd0,7'd33, 3'b000,4'd0, 1'b0,7'd0,  7'd0,  7'd52},
    {1'b1,2'd0,2'd0,7'd127,3'b000,4'd0, 1'b1,7'd127,7'd127,7'd52},
    {1'b1,2'd0,2'd1,7'd3,  3'b000,4'd0, 1'b1,7'd3,  7'd3,  7'd0},
    {1'b1,2'd0,2'd2,7'd0,  3'b000,4'd0, 1'b1,7'd0,  7'd0,  7'd0},
    {1'b0,2'd0,2'd3,7'd0,  3'b000,4'd5, 1'b1,7'd20, 7'd0,  7'd0},
    {1'b0,2'd0,2'd1,7'd9,  3'b000,4'd0, 1'b1,7'd9,  7'd0,  7'd0},
    {1'b1,2'd0,2'd1,7'd9,  3'b000,4'd0, 1'b1,7'd9,  7'd9,  7'd1},
    {1'b1,2'd0,2'd3,7'd0,  3'b000,4'd5, 1'b1,7'd20, 7'd20, 7'd1}
  };

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(logic en, logic [1:0] cd, logic [1:0] bk, logic [6:0] ad,
                       logic [2:0] st, logic [3:0] op);
    step_en   = en;
    cond_sel  = cd;
    br_kind   = bk;
    br_addr   = ad;
    {dr_ind, ac_sign, ac_zero} = st;
    dr_opcode = op;
  endtask

  task automatic step_and_check(string tag, int exp_car, int exp_sbr);
    @(posedge clk);
    #1;
    check({tag, " car"}, car_q, exp_car);
    check({tag, " sbr"}, sbr_q, exp_sbr);
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b0, 2'd0, 2'd0, 7'd0, 3'b000, 4'd0);
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset car", car_q, 64);
    check("R1 reset sbr", sbr_q, 0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      string ctag;
      v = VEC[i];
      @(negedge clk);
      drive(v[40], v[39:38], v[37:36], v[35:29], v[28:26], v[25:22]);
      #1;
      check("R3 cond_hit", cond_hit, v[21]);
      check("R8 next_car", next_car, v[20:14]);
      if (!v[40])              ctag = "R2 hold";
      else if (v[37:36] == 0)  ctag = "R4 jump";
      else if (v[37:36] == 1)  ctag = "R5 call";
      else if (v[37:36] == 2)  ctag = "R6 return";
      else                     ctag = "R7 map";
      @(posedge clk);
      #1;
      check({ctag, " car"}, car_q, v[13:7]);
      check("R9 sbr", sbr_q, v[6:0]);
    end

    // R1: reset wins over an enabled jump
    @(negedge clk);
    rst = 1'b1;
    drive(1'b1, 2'd0, 2'd0, 7'd7, 3'b000, 4'd0);
    step_and_check("R1 reset over jump", 64, 0);
    @(negedge clk);
    rst = 1'b0;

    // R5: nested calls overwrite the single link, return uses the latest
    drive(1'b1, 2'd0, 2'd1, 7'd70, 3'b000, 4'd0);
    step_and_check("R5 first call", 70, 65);
    @(negedge clk);
    drive(1'b1, 2'd0, 2'd1, 7'd80, 3'b000, 4'd0);
    step_and_check("R5 second call", 80, 71);
    @(negedge clk);
    drive(1'b1, 2'd0, 2'd2, 7'd0, 3'b000, 4'd0);
    step_and_check("R6 return after nesting", 71, 71);

    // R3: zero flag selected but clear makes a call fall through
    @(negedge clk);
    drive(1'b1, 2'd3, 2'd1, 7'd100, 3'b110, 4'd0);
    step_and_check("R5 untaken call", 72, 71);

    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule